// File: doc/BRIEF.md
# Bus Parity Checker with Error Logging

This block guards the outbound request path of an I/O bridge. On every request it checks byte-group parity on a 36-bit address. On write requests it also checks byte parity on a 128-bit data word, and each data-byte term includes that byte's write byte-enable. The first failure is captured in a small error log, and a level interrupt is raised while the log is occupied and the interrupt is enabled.

The same block generates per-byte parity for read-completion data. It does this continuously, whether or not checking is enabled. Request strobes, enables and the log-clear pin are plain control pins. The block never stalls and has no ready signal, so every request presented on a clock edge is evaluated on that edge and there is no back-pressure.

Top module: `bus_parity_guard`

## Requirements
- R1: Address parity is even per group: group g (g = 0..3) is address bits 8g+7..8g with `addr_par_i[g]`, and group 4 is bits 35..32 with `addr_par_i[4]`. A group fails when the XOR of its bits and its parity bit is 1. Failing groups appear as ones at the same bit positions in `err_amask_o`.
- R2: On a write request, data byte i (bits 8i+7..8i) fails when the XOR of its eight bits, `wdata_par_i[i]` and `wbe_i[i]` is 1. Failing bytes appear at bit i of `err_dmask_o`.
- R3: A read request (`req_rd_i` high, `req_wr_i` low) checks only the address. Its data, data parity and byte enables never cause a logged error.
- R4: A failing request raises `err_vld_o` at the clock edge after the request cycle. On that edge the log captures the request address in `err_addr_o` and both masks. `err_kind_o` bit 0 marks an address failure and bit 1 marks a data failure.
- R5: Address and data failures in the same request are logged together in one entry, with both kind bits set.
- R6: While `err_vld_o` is set, the log fields hold their values. A further failing request only sets the sticky `err_ovf_o`.
- R7: `log_clr_i` clears `err_vld_o` and `err_ovf_o` at the next edge. A failing request in the same cycle as the clear is captured as a fresh entry, with no overflow.
- R8: `irq_o` is high exactly while `err_vld_o` and `irq_en_i` are both high.
- R9: With `par_en_i` low during the request cycle, no request is checked and the log does not change.
- R10: `cpl_par_o[i]` is the XOR of completion byte i, so that byte i together with its parity bit has even parity. Byte enables are taken as 0, and the output does not depend on `par_en_i`.
- R11: After reset, all log outputs, `err_ovf_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd_i | input | 1 | Outbound read request strobe |
| req_wr_i | input | 1 | Outbound write request strobe |
| addr_i | input | 36 | Request address |
| addr_par_i | input | 5 | Address group parity bits |
| wdata_i | input | 128 | Write data |
| wdata_par_i | input | 16 | Write data byte parity bits |
| wbe_i | input | 16 | Write byte enables |
| cpl_data_i | input | 128 | Read-completion data |
| par_en_i | input | 1 | Parity checking enable |
| irq_en_i | input | 1 | Interrupt enable |
| log_clr_i | input | 1 | Clear the error log and overflow |
| cpl_par_o | output | 16 | Generated completion byte parity |
| err_vld_o | output | 1 | Error log holds an entry |
| err_kind_o | output | 2 | Bit 0 address failure, bit 1 data failure |
| err_addr_o | output | 36 | Logged request address |
| err_amask_o | output | 5 | Logged failing address groups |
| err_dmask_o | output | 16 | Logged failing data bytes |
| err_ovf_o | output | 1 | Sticky: failure seen while log full |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sends writes and reads with correct parity under random data, which separates a correct even-parity check from an inverted or mis-grouped one. It then flips single bits in turn: a bit in the partial top address group, a data parity bit, and a lone byte enable. Each flip must mark exactly one mask position, which exposes wrong group boundaries or a dropped byte-enable term. Reads with corrupted data, disabled checking, and back-to-back failures with and without a simultaneous clear tell apart which request kinds and which cycles may write the log. A random mixed phase with rare errors covers interleavings of clear, overflow and interrupt enable.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int GRP_W = 8;

  function automatic int grp_count(input int width);
    return (width + GRP_W - 1) / GRP_W;
  endfunction

  typedef struct packed {
    logic data_hit;
    logic addr_hit;
  } bpg_kind_t;
endpackage

// File: rtl/bpg_grp_xor.sv
module bpg_grp_xor
  import bpg_pkg::*;
#(
  parameter int W = 36,
  localparam int NG = grp_count(W)
) (
  input  logic [W-1:0]  vec_i,
  input  logic [NG-1:0] extra_i,
  output logic [NG-1:0] x_o
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = g * GRP_W;
    localparam int HI = ((g + 1) * GRP_W > W) ? W - 1 : (g + 1) * GRP_W - 1;
    assign x_o[g] = (^vec_i[HI:LO]) ^ extra_i[g];
  end
endmodule

// File: rtl/bpg_err_log.sv
module bpg_err_log
  import bpg_pkg::*;
#(
  parameter int AW = 36,
  parameter int NA = 5,
  parameter int ND = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NA-1:0] amask_i,
  input  logic [ND-1:0] dmask_i,
  input  logic          clr_i,
  output logic          vld_o,
  output bpg_kind_t     kind_o,
  output logic [AW-1:0] addr_o,
  output logic [NA-1:0] amask_o,
  output logic [ND-1:0] dmask_o,
  output logic          ovf_o
);
  logic take;
  assign take = evt_i && (!vld_o || clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o   <= 1'b0;
      kind_o  <= '0;
      addr_o  <= '0;
      amask_o <= '0;
      dmask_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (clr_i) begin
        vld_o <= 1'b0;
        ovf_o <= 1'b0;
      end
      if (take) begin
        vld_o           <= 1'b1;
        addr_o          <= addr_i;
        amask_o         <= amask_i;
        dmask_o         <= dmask_i;
        kind_o.addr_hit <= |amask_i;
        kind_o.data_hit <= |dmask_i;
      end else if (evt_i && !clr_i) begin
        ovf_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_parity_guard.sv
module bus_parity_guard
  import bpg_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 128,
  localparam int NA = grp_count(ADDR_W),
  localparam int ND = grp_count(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NA-1:0]     addr_par_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ND-1:0]     wdata_par_i,
  input  logic [ND-1:0]     wbe_i,
  input  logic [DATA_W-1:0] cpl_data_i,
  input  logic              par_en_i,
  input  logic              irq_en_i,
  input  logic              log_clr_i,
  output logic [ND-1:0]     cpl_par_o,
  output logic              err_vld_o,
  output logic [1:0]        err_kind_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [NA-1:0]     err_amask_o,
  output logic [ND-1:0]     err_dmask_o,
  output logic              err_ovf_o,
  output logic              irq_o
);
  logic [NA-1:0] a_fail;
  logic [ND-1:0] d_x;
  logic [ND-1:0] d_fail;
  logic          evt;
  bpg_kind_t     kind;

  // Address: parity bit folded in as the extra term.
  bpg_grp_xor #(.W(ADDR_W)) u_addr_chk (
    .vec_i  (addr_i),
    .extra_i(addr_par_i),
    .x_o    (a_fail)
  );

  // Write data: parity bit and byte enable both folded in.
  bpg_grp_xor #(.W(DATA_W)) u_data_chk (
    .vec_i  (wdata_i),
    .extra_i(wdata_par_i ^ wbe_i),
    .x_o    (d_x)
  );

  // Completion: enables taken as zero, parity makes each byte even.
  bpg_grp_xor #(.W(DATA_W)) u_cpl_gen (
    .vec_i  (cpl_data_i),
    .extra_i('0),
    .x_o    (cpl_par_o)
  );

  assign d_fail = req_wr_i ? d_x : '0;
  assign evt    = (req_rd_i || req_wr_i) && par_en_i && ((|a_fail) || (|d_fail));

  bpg_err_log #(.AW(ADDR_W), .NA(NA), .ND(ND)) u_log (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt),
    .addr_i (addr_i),
    .amask_i(a_fail),
    .dmask_i(d_fail),
    .clr_i  (log_clr_i),
    .vld_o  (err_vld_o),
    .kind_o (kind),
    .addr_o (err_addr_o),
    .amask_o(err_amask_o),
    .dmask_o(err_dmask_o),
    .ovf_o  (err_ovf_o)
  );

  assign err_kind_o = kind;
  assign irq_o      = err_vld_o && irq_en_i;
endmodule

// File: rtl/bpg_sva.sv
module bpg_sva #(
  parameter int NA = 5,
  parameter int ND = 16,
  parameter int AW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_rd_i,
  input logic          req_wr_i,
  input logic          par_en_i,
  input logic          irq_en_i,
  input logic          log_clr_i,
  input logic          err_vld_o,
  input logic [1:0]    err_kind_o,
  input logic [AW-1:0] err_addr_o,
  input logic [NA-1:0] err_amask_o,
  input logic [ND-1:0] err_dmask_o,
  input logic          err_ovf_o,
  input logic          irq_o
);
  p_flag_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_vld_o) |-> $past(req_rd_i || req_wr_i) && $past(par_en_i));

  p_read_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_vld_o) && $past(!req_wr_i)) |-> (err_dmask_o == '0));

  p_kind_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld_o |-> (err_kind_o[0] == (|err_amask_o)) && (err_kind_o[1] == (|err_dmask_o)));

  p_log_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld_o && !log_clr_i) |=> err_vld_o && $stable(err_addr_o)
      && $stable(err_amask_o) && $stable(err_dmask_o));

  p_ovf_needs_log_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf_o |-> err_vld_o);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (log_clr_i && !par_en_i) |=> !err_vld_o && !err_ovf_o);

  p_no_check_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_en_i && !err_vld_o) |=> !err_vld_o);

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> err_vld_o && irq_en_i);
endmodule

bind bus_parity_guard bpg_sva #(.NA(NA), .ND(ND), .AW(ADDR_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_rd_i   (req_rd_i),
  .req_wr_i   (req_wr_i),
  .par_en_i   (par_en_i),
  .irq_en_i   (irq_en_i),
  .log_clr_i  (log_clr_i),
  .err_vld_o  (err_vld_o),
  .err_kind_o (err_kind_o),
  .err_addr_o (err_addr_o),
  .err_amask_o(err_amask_o),
  .err_dmask_o(err_dmask_o),
  .err_ovf_o  (err_ovf_o),
  .irq_o      (irq_o)
);

// File: tb/test_bus_parity_guard.sv
module test_bus_parity_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         req_rd_i = 0, req_wr_i = 0;
  logic [35:0]  addr_i = '0;
  logic [4:0]   addr_par_i = '0;
  logic [127:0] wdata_i = '0, cpl_data_i = '0;
  logic [15:0]  wdata_par_i = '0, wbe_i = '0;
  logic         par_en_i = 1, irq_en_i = 1, log_clr_i = 0;
  logic [15:0]  cpl_par_o;
  logic         err_vld_o, err_ovf_o, irq_o;
  logic [1:0]   err_kind_o;
  logic [35:0]  err_addr_o;
  logic [4:0]   err_amask_o;
  logic [15:0]  err_dmask_o;

  bus_parity_guard i_bus_parity_guard (.*);

  int n_cmp = 0, n_bad = 0;
  string tag = "R11";

  // reference state
  bit          m_vld, m_ovf;
  bit [1:0]    m_kind;
  bit [35:0]   m_addr;
  bit [4:0]    m_am;
  bit [15:0]   m_dm;

  function automatic bit odd_ones(input logic [127:0] v, input int lo, input int n);
    int c = 0;
    for (int k = 0; k < n; k++) if (v[lo + k]) c++;
    return (c % 2) == 1;
  endfunction

  function automatic logic [4:0] apar_of(input logic [35:0] a);
    logic [4:0] p;
    for (int g = 0; g < 5; g++) p[g] = odd_ones({92'b0, a}, 8 * g, (g == 4) ? 4 : 8);
    return p;
  endfunction

  function automatic logic [15:0] dpar_of(input logic [127:0] d, input logic [15:0] be);
    logic [15:0] p;
    for (int i = 0; i < 16; i++) p[i] = odd_ones(d, 8 * i, 8) ^ be[i];
    return p;
  endfunction

  task automatic cmp(input string what, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cycle();
    bit [4:0] am; bit [15:0] dm; bit evt, old_vld;
    #1;
    cmp("cpl_par", cpl_par_o, dpar_of(cpl_data_i, 16'h0));
    cmp("irq", irq_o, m_vld && irq_en_i);
    am = apar_of(addr_i) ^ addr_par_i;
    dm = req_wr_i ? (dpar_of(wdata_i, wbe_i) ^ wdata_par_i) : 16'h0;
    evt = (req_rd_i || req_wr_i) && par_en_i && (am != 0 || dm != 0);
    old_vld = m_vld;
    @(posedge clk);
    if (log_clr_i) begin m_vld = 0; m_ovf = 0; end
    if (evt) begin
      if (!old_vld || log_clr_i) begin
        m_vld = 1; m_addr = addr_i; m_am = am; m_dm = dm;
        m_kind = {dm != 0, am != 0};
      end else m_ovf = 1;
    end
    @(negedge clk);
    cmp("err_vld", err_vld_o, m_vld);
    cmp("err_ovf", err_ovf_o, m_ovf);
    cmp("err_kind", err_kind_o, m_kind);
    cmp("err_addr", err_addr_o, m_addr);
    cmp("err_amask", err_amask_o, m_am);
    cmp("err_dmask", err_dmask_o, m_dm);
    cmp("irq_reg", irq_o, m_vld && irq_en_i);
  endtask

  task automatic idle();
    req_rd_i = 0; req_wr_i = 0; log_clr_i = 0;
    cpl_data_i = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic good_wr(input logic [35:0] a, input logic [127:0] d, input logic [15:0] be);
    req_wr_i = 1; req_rd_i = 0; addr_i = a; addr_par_i = apar_of(a);
    wdata_i = d; wbe_i = be; wdata_par_i = dpar_of(d, be);
  endtask

  task automatic clear_log();
    idle(); log_clr_i = 1; cycle(); log_clr_i = 0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [35:0] rnd36();
    return {$urandom, $urandom} & 36'hF_FFFF_FFFF;
  endfunction

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        n_bad++; n_cmp++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    m_vld = 0; m_ovf = 0; m_kind = 0; m_addr = 0; m_am = 0; m_dm = 0;
    repeat (3) @(negedge clk);
    tag = "R11";
    cmp("vld_in_reset", err_vld_o, 1'b0);
    rst_n = 1;
    idle(); cycle();

    tag = "R1";  // clean traffic: no error
    for (int i = 0; i < 20; i++) begin good_wr(rnd36(), rnd128(), 16'($urandom)); cycle(); end
    tag = "R1";  // partial top group, bit 33
    good_wr(36'h3_0000_1234, rnd128(), 16'h0); addr_i[33] = ~addr_i[33]; cycle();
    tag = "R4"; idle(); cycle();
    tag = "R7"; clear_log();

    tag = "R2";  // byte enable alone flips byte 7
    good_wr(rnd36(), rnd128(), 16'h00F0); wbe_i[7] = ~wbe_i[7]; cycle();
    idle(); cycle(); clear_log();
    tag = "R2";  // data parity bit 15
    good_wr(rnd36(), rnd128(), 16'hFFFF); wdata_par_i[15] = ~wdata_par_i[15]; cycle();
    idle(); cycle(); clear_log();

    tag = "R3";  // read with bad data side
    good_wr(rnd36(), rnd128(), 16'h0); req_wr_i = 0; req_rd_i = 1; wdata_par_i = ~wdata_par_i;
    cycle(); idle(); cycle();
    tag = "R3";  // read with bad address is still logged
    good_wr(rnd36(), rnd128(), 16'h0); req_wr_i = 0; req_rd_i = 1; addr_par_i[0] = ~addr_par_i[0];
    cycle(); idle(); cycle(); clear_log();

    tag = "R5";
    good_wr(rnd36(), rnd128(), 16'h0); addr_par_i[2] = ~addr_par_i[2]; wdata_par_i[3] = ~wdata_par_i[3];
    cycle(); idle(); cycle();

    tag = "R6";  // log full: later error only overflows
    good_wr(rnd36(), rnd128(), 16'h0); addr_par_i[1] = ~addr_par_i[1]; cycle();
    idle(); cycle();
    tag = "R8"; irq_en_i = 0; cycle(); irq_en_i = 1; cycle();

    tag = "R7";  // clear with simultaneous error: fresh entry, no overflow
    good_wr(rnd36(), rnd128(), 16'h0); wdata_par_i[9] = ~wdata_par_i[9]; log_clr_i = 1; cycle();
    idle(); cycle(); clear_log(); cycle();

    tag = "R9";  // checking off
    par_en_i = 0;
    good_wr(rnd36(), rnd128(), 16'h0); addr_par_i = ~addr_par_i; wdata_par_i = ~wdata_par_i; cycle();
    tag = "R10"; idle(); for (int i = 0; i < 5; i++) begin cpl_data_i = rnd128(); cycle(); end
    par_en_i = 1;

    tag = "R10";  // random mixed traffic
    for (int i = 0; i < 400; i++) begin
      good_wr(rnd36(), rnd128(), 16'($urandom));
      if ($urandom % 2) begin req_wr_i = 0; req_rd_i = 1; end
      if ($urandom % 8 == 0) addr_par_i[$urandom % 5] ^= 1'b1;
      if ($urandom % 8 == 0) wdata_par_i[$urandom % 16] ^= 1'b1;
      if ($urandom % 4 == 0) begin req_wr_i = 0; req_rd_i = 0; end
      log_clr_i = ($urandom % 10 == 0);
      irq_en_i  = ($urandom % 4 != 0);
      par_en_i  = ($urandom % 6 != 0);
      cpl_data_i = rnd128();
      cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule